// File: doc/BRIEF.md
# CPU Presence Bitmap with Hot-Add Event

This block keeps one bit per possible processor in a 32-byte I/O window, one byte per access. The bit position equals the processor's interrupt-controller ID. A hot-add request from the platform side sets that processor's bit. It also raises a general-purpose event status bit (bit 2), and the level interrupt output follows that status bit. Bit 0 stands for the boot processor and always reads as 1. No bit is ever cleared except by reset.

The bus can only read the bitmap, with one exception. A zero byte written anywhere in the first four bytes of the window is a one-way switch: it latches a mode flag that hands the window to a newer register interface, which lives outside this block. From then until reset the block drives zero on its read data. Every other bus write has no effect.

Top module: `cpumap_top`

## Requirements
- R1: After reset, the bitmap holds only bit 0, `gpe_status` is 0x00, `sci` is 0 and `modern_mode` is 0.
- R2: A read (`io_rd`=1) at address BASE_ADDR+k, with k from 0 to 31, returns bitmap bits 8k+7..8k on `io_rdata` in the next cycle. In any cycle after one with no read, or with a read outside the window, `io_rdata` is 0x00.
- R3: Bit 0 of the bitmap reads as 1 at all times. A hot-add of ID 0 leaves it set.
- R4: A hot-add (`hotadd_valid`=1) with `hotadd_id` below MAX_CPUS sets bitmap bit `hotadd_id`, visible to reads from the next cycle. An ID at or above MAX_CPUS changes neither the bitmap nor the status.
- R5: A valid hot-add sets `gpe_status` bit 2 and drives `sci` high in the next cycle.
- R6: `sci` equals `gpe_status` bit 2. A `gpe_clr_wr` with `gpe_clr_data` bit 2 = 1 clears the bit in the next cycle. With bit 2 = 0 it has no effect.
- R7: When a valid hot-add and a clear fall in the same cycle, `gpe_status` bit 2 stays set.
- R8: Set bitmap bits are never cleared. Bus writes of non-zero data, and bus writes to offsets 4 to 31, change neither the bitmap nor the mode flag.
- R9: A write of 0x00 to offset 0, 1, 2 or 3 sets `modern_mode` in the next cycle. The flag stays set until reset.
- R10: While `modern_mode` is 1, every read returns 0x00.
- R11: Bytes at offsets from MAX_CPUS/8 up to 31 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Byte address of the I/O access |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered, valid the cycle after `io_rd` |
| hotadd_valid | input | 1 | Hot-add request |
| hotadd_id | input | 8 | Interrupt-controller ID of the added processor |
| gpe_clr_wr | input | 1 | Write strobe of the event status register (write 1 to clear) |
| gpe_clr_data | input | 8 | Data for the event status write |
| gpe_status | output | 8 | Event status; only bit 2 is ever set |
| sci | output | 1 | Level interrupt, high while status bit 2 is set |
| modern_mode | output | 1 | Latched hand-over to the newer register interface |

## Verification
A hot-add request and a write-1-to-clear of status bit 2 can land in the same cycle. The bench drives both strobes on one clock edge. It then expects bit 2 and `sci` still set, so the new event is not lost. A second clear alone must then drop both. The bench also sends a bus read in the cycle that follows a hot-add, and the scoreboard expects the new bit in that read's data.

// File: rtl/cpumap_pkg.sv
package cpumap_pkg;

    localparam int WIN_BYTES      = 32;
    localparam int WIN_AW         = 5;
    localparam int WIN_BITS       = WIN_BYTES * 8;
    localparam int ID_W           = 8;
    localparam int GPE_W          = 8;
    localparam int HOTADD_GPE_BIT = 2;
    localparam int SWITCH_BYTES   = 4;

    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_MODERN = 1'b1
    } if_mode_e;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } hotadd_t;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic              hit;
        logic [WIN_AW-1:0] off;
        logic [7:0]        wdata;
    } bus_req_t;

    function automatic logic in_window(input logic [15:0] addr, input logic [15:0] base);
        logic [15:0] delta;
        delta = addr - base;
        return delta < 16'(WIN_BYTES);
    endfunction

    function automatic logic is_switch_write(input bus_req_t req);
        return req.wr && req.hit && (int'(req.off) < SWITCH_BYTES) && (req.wdata == 8'h00);
    endfunction

    function automatic logic id_in_range(input logic [ID_W-1:0] id, input int max_cpus);
        return int'(id) < max_cpus;
    endfunction

endpackage

// File: rtl/cpumap_store.sv
module cpumap_store
    import cpumap_pkg::*;
#(
    parameter int MAX_CPUS = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  hotadd_t             add,
    output logic [MAX_CPUS-1:0] map_q
);

    for (genvar i = 0; i < MAX_CPUS; i++) begin : g_bit
        if (i == 0) begin : g_boot
            always_ff @(posedge clk) begin
                if (rst) map_q[i] <= 1'b1;
                else     map_q[i] <= 1'b1;
            end
        end else begin : g_hot
            always_ff @(posedge clk) begin
                if (rst)
                    map_q[i] <= 1'b0;
                else if (add.valid && add.id == ID_W'(i))
                    map_q[i] <= 1'b1;
            end
        end
    end

    // R8
    no_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (($past(map_q) & ~map_q) == '0));

    // R4
    add_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (add.valid && id_in_range(add.id, MAX_CPUS)) |=> map_q[$past(add.id)]);

    // R3
    boot_bit_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> map_q[0]);

endmodule

// File: rtl/cpumap_event.sv
module cpumap_event
    import cpumap_pkg::*;
#(
    parameter int MAX_CPUS = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  hotadd_t          add,
    input  logic             clr_wr,
    input  logic [GPE_W-1:0] clr_data,
    output logic [GPE_W-1:0] gpe_q,
    output logic             sci_q
);

    logic add_hit;
    logic clr_hit;
    logic ev_next;
    logic unused_clr;

    assign add_hit    = add.valid && id_in_range(add.id, MAX_CPUS);
    assign clr_hit    = clr_wr && clr_data[HOTADD_GPE_BIT];
    assign ev_next    = add_hit || (gpe_q[HOTADD_GPE_BIT] && !clr_hit);
    assign unused_clr = ^{clr_data[GPE_W-1:HOTADD_GPE_BIT+1], clr_data[HOTADD_GPE_BIT-1:0]};

    for (genvar b = 0; b < GPE_W; b++) begin : g_gpe
        if (b == HOTADD_GPE_BIT) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) gpe_q[b] <= 1'b0;
                else     gpe_q[b] <= ev_next;
            end
        end else begin : g_idle
            always_ff @(posedge clk) begin
                gpe_q[b] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sci_q <= 1'b0;
        else     sci_q <= ev_next;
    end

    // R5
    add_raises_chk: assert property (@(posedge clk) disable iff (rst)
        add_hit |=> (gpe_q[HOTADD_GPE_BIT] && sci_q));

    // R6
    sci_track_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (sci_q == gpe_q[HOTADD_GPE_BIT]));

    // R6
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && !add_hit) |=> !sci_q);

    // R4
    bad_id_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (add.valid && !add_hit && !gpe_q[HOTADD_GPE_BIT]) |=> !gpe_q[HOTADD_GPE_BIT]);

endmodule

// File: rtl/cpumap_readout.sv
module cpumap_readout
    import cpumap_pkg::*;
#(
    parameter int          MAX_CPUS  = 64,
    parameter logic [15:0] BASE_ADDR = 16'haf00
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [15:0]         io_addr,
    input  logic                io_rd,
    input  logic                io_wr,
    input  logic [7:0]          io_wdata,
    input  logic [MAX_CPUS-1:0] map,
    output logic [7:0]          rdata_q,
    output if_mode_e            mode_q
);

    localparam int PAD_BITS = WIN_BITS - MAX_CPUS;

    logic [WIN_BITS-1:0] padded;
    logic [15:0]         delta;
    bus_req_t            req;
    logic [7:0]          sel_byte;
    logic                unused_delta;

    if (PAD_BITS > 0) begin : g_pad
        assign padded = {{PAD_BITS{1'b0}}, map};
    end else begin : g_full
        assign padded = map;
    end

    assign delta        = io_addr - BASE_ADDR;
    assign unused_delta = ^delta[15:WIN_AW];

    always_comb begin
        req.rd    = io_rd;
        req.wr    = io_wr;
        req.hit   = in_window(io_addr, BASE_ADDR);
        req.off   = delta[WIN_AW-1:0];
        req.wdata = io_wdata;
    end

    assign sel_byte = padded[int'(req.off)*8 +: 8];

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_LEGACY;
        else if (is_switch_write(req))
            mode_q <= MODE_MODERN;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= 8'h00;
        else if (req.rd && req.hit && mode_q == MODE_LEGACY)
            rdata_q <= sel_byte;
        else
            rdata_q <= 8'h00;
    end

    // R9
    mode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_MODERN) |=> (mode_q == MODE_MODERN));

    // R9
    mode_set_chk: assert property (@(posedge clk) disable iff (rst)
        is_switch_write(req) |=> (mode_q == MODE_MODERN));

    // R10
    modern_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_MODERN) |=> (rdata_q == 8'h00));

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !(req.rd && req.hit) |=> (rdata_q == 8'h00));

endmodule

// File: rtl/cpumap_top.sv
module cpumap_top
    import cpumap_pkg::*;
#(
    parameter int          MAX_CPUS  = 64,
    parameter logic [15:0] BASE_ADDR = 16'haf00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] io_addr,
    input  logic        io_rd,
    input  logic        io_wr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    input  logic        hotadd_valid,
    input  logic [7:0]  hotadd_id,
    input  logic        gpe_clr_wr,
    input  logic [7:0]  gpe_clr_data,
    output logic [7:0]  gpe_status,
    output logic        sci,
    output logic        modern_mode
);

    hotadd_t             add;
    logic [MAX_CPUS-1:0] map;
    if_mode_e            mode;

    initial begin
        if (MAX_CPUS < 8 || MAX_CPUS > WIN_BITS)
            $error("MAX_CPUS out of range");
    end

    assign add.valid = hotadd_valid;
    assign add.id    = hotadd_id;

    cpumap_store #(.MAX_CPUS(MAX_CPUS)) u_store (
        .clk   (clk),
        .rst   (rst),
        .add   (add),
        .map_q (map)
    );

    cpumap_event #(.MAX_CPUS(MAX_CPUS)) u_event (
        .clk      (clk),
        .rst      (rst),
        .add      (add),
        .clr_wr   (gpe_clr_wr),
        .clr_data (gpe_clr_data),
        .gpe_q    (gpe_status),
        .sci_q    (sci)
    );

    cpumap_readout #(.MAX_CPUS(MAX_CPUS), .BASE_ADDR(BASE_ADDR)) u_readout (
        .clk      (clk),
        .rst      (rst),
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .io_wdata (io_wdata),
        .map      (map),
        .rdata_q  (io_rdata),
        .mode_q   (mode)
    );

    assign modern_mode = (mode == MODE_MODERN);

endmodule

// File: tb/test_cpumap_top.sv
module test_cpumap_top;

    localparam int          NCPU = 64;
    localparam logic [15:0] BASE = 16'haf00;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        hotadd_valid = 1'b0;
    logic [7:0]  hotadd_id = '0;
    logic        gpe_clr_wr = 1'b0;
    logic [7:0]  gpe_clr_data = '0;
    logic [7:0]  gpe_status;
    logic        sci;
    logic        modern_mode;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    logic [255:0] m_map;
    bit           m_mode;
    rd_item_t     rd_q[$];
    logic         rd_cap = 1'b0;

    always #2.5 clk = ~clk;

    cpumap_top #(.MAX_CPUS(NCPU), .BASE_ADDR(BASE)) i_cpumap_top (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .hotadd_valid(hotadd_valid),
        .hotadd_id(hotadd_id), .gpe_clr_wr(gpe_clr_wr), .gpe_clr_data(gpe_clr_data),
        .gpe_status(gpe_status), .sci(sci), .modern_mode(modern_mode)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [15:0] a);
        logic [15:0] d;
        d = a - BASE;
        if (m_mode || d >= 16'd32) return 8'h00;
        return m_map[int'(d[4:0])*8 +: 8];
    endfunction

    // monitor: pops expected read data the cycle after each read strobe
    always @(posedge clk) rd_cap <= io_rd;

    always @(negedge clk) begin
        if (rd_cap) begin
            if (rd_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2: actual %02h expected <no read queued>", io_rdata);
            end else begin
                rd_item_t it;
                it = rd_q.pop_front();
                chk(it.tag, io_rdata, it.exp);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        m_map = 256'd1;
        m_mode = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.exp = exp_byte(a);
        it.tag = tag;
        rd_q.push_back(it);
        io_addr = a;
        io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        logic [15:0] off;
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        off = a - BASE;
        if (off < 16'd4 && d == 8'h00) m_mode = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic do_add(input logic [7:0] id, input bit with_clr);
        @(negedge clk);
        hotadd_valid = 1'b1; hotadd_id = id;
        if (with_clr) begin gpe_clr_wr = 1'b1; gpe_clr_data = 8'h04; end
        if (int'(id) < NCPU) m_map[id] = 1'b1;
        @(negedge clk);
        hotadd_valid = 1'b0; gpe_clr_wr = 1'b0;
    endtask

    task automatic do_clr(input logic [7:0] d);
        @(negedge clk);
        gpe_clr_wr = 1'b1; gpe_clr_data = d;
        @(negedge clk);
        gpe_clr_wr = 1'b0;
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        do_reset();
        chk("R1 gpe", gpe_status, 8'h00);
        chk("R1 sci", {7'b0, sci}, 8'h00);
        chk("R1 mode", {7'b0, modern_mode}, 8'h00);
        do_read(BASE, "R1 R3 byte0");
        do_read(BASE + 16'd1, "R1 byte1");

        do_add(8'd5, 1'b0);
        chk("R5 gpe", gpe_status, 8'h04);
        chk("R5 sci", {7'b0, sci}, 8'h01);
        do_read(BASE, "R4 byte0 id5");
        do_clr(8'hFB);
        chk("R6 no-clear", gpe_status, 8'h04);
        do_clr(8'h04);
        chk("R6 cleared gpe", gpe_status, 8'h00);
        chk("R6 cleared sci", {7'b0, sci}, 8'h00);

        do_add(8'd0, 1'b0);
        do_read(BASE, "R3 id0");
        do_add(8'd63, 1'b0);
        do_read(BASE + 16'd7, "R4 id63");
        do_clr(8'h04);
        do_add(8'd64, 1'b0);
        chk("R4 bad id gpe", gpe_status, 8'h00);
        do_add(8'd200, 1'b0);
        chk("R4 bad id sci", {7'b0, sci}, 8'h00);
        do_read(BASE + 16'd8, "R11 byte8");
        do_read(BASE + 16'd31, "R11 byte31");
        do_read(BASE + 16'd32, "R2 above window");
        do_read(BASE - 16'd1, "R2 below window");

        do_add(8'd10, 1'b1);
        chk("R7 gpe", gpe_status, 8'h04);
        chk("R7 sci", {7'b0, sci}, 8'h01);
        do_read(BASE + 16'd1, "R4 id10");
        do_clr(8'h04);
        chk("R6 after R7", {7'b0, sci}, 8'h00);

        do_write(BASE, 8'hFF);
        do_write(BASE + 16'd4, 8'h00);
        do_write(BASE + 16'd1, 8'h00 ^ 8'h01);
        chk("R8 mode", {7'b0, modern_mode}, 8'h00);
        do_read(BASE, "R8 byte0");
        do_read(BASE + 16'd1, "R8 byte1");

        do_write(BASE + 16'd3, 8'h00);
        chk("R9 mode set", {7'b0, modern_mode}, 8'h01);
        do_read(BASE, "R10 byte0");
        do_read(BASE + 16'd7, "R10 byte7");
        do_write(BASE + 16'd3, 8'h55);
        repeat (3) @(negedge clk);
        chk("R9 mode held", {7'b0, modern_mode}, 8'h01);

        do_reset();
        chk("R1 mode after reset", {7'b0, modern_mode}, 8'h00);
        do_read(BASE, "R1 byte0 after reset");
        do_read(BASE + 16'd7, "R1 byte7 after reset");

        repeat (3) @(negedge clk);
        if (rd_q.size() != 0) chk("R2 pending reads", 8'(rd_q.size()), 8'h00);
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule